// File: doc/BRIEF.md
# Lane Electrical-Idle and Auto-Low-Power Tracker

This block sits in the control logic of a multi-lane signal conditioner. Each lane has an analog squelch comparator that flags when the received differential swing is below the idle threshold. The block carries that flag through a two-stage synchroniser. It then commands the lane's transmitter into electrical idle straight away, so the output follows the input's idle state with only the synchroniser's latency.

A deeper per-lane low-power state is entered only after idle has held without a break for a programmable number of clock cycles, the qualification time. That time is 250 cycles by default, which is 1 µs at 250 MHz. Low power also needs the power-save strap high and the lane marked active by the mode controller. The state is left as soon as activity returns. Dropping the lane out of active mode, into sleep or receiver detect, also ends it and clears the qualification timer.

A device-level indication is high only while every lane is in low power at once.

Top module: `lane_idle_pwr_ctrl`

## Requirements
- R1: After reset all outputs are 0. `tx_idle_o[i]` equals `squelch_i[i]` (1 = input below the idle threshold) as sampled two rising clock edges earlier.
- R2: The lanes are independent. Squelch, activity and timer state on one lane have no effect on another lane's `tx_idle_o` or `ch_lp_o`.
- R3: A lane whose `ch_active_i` bit is 0 never has `ch_lp_o` high, while its `tx_idle_o` still follows squelch.
- R4: With `pwr_save_en_i`=1 and the lane active, `squelch_i` held at 1 from just before edge E0 makes `ch_lp_o` go high after edge E(QUAL_CYCLES+1). It is low after E(QUAL_CYCLES).
- R5: Once `squelch_i` falls, `ch_lp_o` and `tx_idle_o` are low no later than after the second rising edge that samples the new value.
- R6: With `pwr_save_en_i`=0, `ch_lp_o` stays 0 through idle of any length. If the strap is raised during idle, qualification starts from zero and `ch_lp_o` rises after the QUAL_CYCLES-th edge from then on.
- R7: `all_lp_o` is 1 exactly when every lane's `ch_lp_o` is 1.
- R8: If `ch_active_i` is low at a rising edge, `ch_lp_o` is low in the cycle that follows and the timer is cleared. After the lane becomes active again while still idle, `ch_lp_o` rises after the QUAL_CYCLES-th edge.
- R9: An idle burst of L edges gives max(0, L−QUAL_CYCLES) cycles of `ch_lp_o`. Activity that returns one cycle before expiry (L = QUAL_CYCLES) gives none, and L = QUAL_CYCLES+1 gives exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| squelch_i | input | NUM_CH | Per-lane comparator flag, 1 = swing below idle threshold (asynchronous) |
| pwr_save_en_i | input | 1 | Power-save strap; 1 allows auto-low-power |
| ch_active_i | input | NUM_CH | Per-lane active-mode status from the mode controller |
| tx_idle_o | output | NUM_CH | Per-lane transmitter electrical-idle command |
| ch_lp_o | output | NUM_CH | Per-lane low-power enable |
| all_lp_o | output | 1 | All lanes in low power |

## Verification
The timer is driven with idle bursts of exactly QUAL_CYCLES, one edge longer and several edges longer. These separate an off-by-one entry point from a correct one, and counting low-power cycles per burst also exposes a late exit. Idle held with the strap low and then raised, and a lane dropped from active mode and brought back, show whether the timer is really cleared or only masked. Idle on one lane while the other stays busy shows that the lanes are independent and that the device-level flag needs both. A long stretch of random per-lane run lengths spread around the qualification time, mixed with rare strap and activity changes, is compared cycle by cycle against a bench model.

// File: rtl/lane_idle_pkg.sv
`timescale 1ns/1ps
package lane_idle_pkg;
  localparam int unsigned DEF_NUM_CH      = 2;
  localparam int unsigned DEF_QUAL_CYCLES = 250;  // 1 us at 250 MHz

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/sync_2ff.sv
`timescale 1ns/1ps
module sync_2ff #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/lp_qual_timer.sv
`timescale 1ns/1ps
module lp_qual_timer
  import lane_idle_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = DEF_QUAL_CYCLES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = cnt_width(QUAL_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  // gated by run_i so exit needs no clock edge
  assign expired_o = run_i && (cnt_q == LIMIT);
endmodule

// File: rtl/lane_idle_ch.sv
`timescale 1ns/1ps
module lane_idle_ch
  import lane_idle_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = DEF_QUAL_CYCLES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic squelch_i,
  input  logic pwr_save_en_i,
  input  logic active_i,
  output logic tx_idle_o,
  output logic lp_o
);
  logic sq_sync;
  logic qual_run;

  sync_2ff #(.WIDTH(1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (squelch_i),
    .q_o    (sq_sync)
  );

  assign qual_run = sq_sync && pwr_save_en_i && active_i;

  lp_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (qual_run),
    .expired_o (lp_o)
  );

  assign tx_idle_o = sq_sync;
endmodule

// File: rtl/lane_idle_pwr_ctrl.sv
`timescale 1ns/1ps
module lane_idle_pwr_ctrl
  import lane_idle_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned QUAL_CYCLES = DEF_QUAL_CYCLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] squelch_i,
  input  logic              pwr_save_en_i,
  input  logic [NUM_CH-1:0] ch_active_i,
  output logic [NUM_CH-1:0] tx_idle_o,
  output logic [NUM_CH-1:0] ch_lp_o,
  output logic              all_lp_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    lane_idle_ch #(.QUAL_CYCLES(QUAL_CYCLES)) u_lane (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .squelch_i     (squelch_i[g]),
      .pwr_save_en_i (pwr_save_en_i),
      .active_i      (ch_active_i[g]),
      .tx_idle_o     (tx_idle_o[g]),
      .lp_o          (ch_lp_o[g])
    );
  end

  assign all_lp_o = &ch_lp_o;
endmodule

// File: rtl/lane_idle_pwr_chk.sv
`timescale 1ns/1ps
module lane_idle_pwr_chk
  import lane_idle_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned QUAL_CYCLES = DEF_QUAL_CYCLES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] squelch_i,
  input logic              pwr_save_en_i,
  input logic [NUM_CH-1:0] ch_active_i,
  input logic [NUM_CH-1:0] tx_idle_o,
  input logic [NUM_CH-1:0] ch_lp_o,
  input logic              all_lp_o
);
  localparam int unsigned CW = cnt_width(QUAL_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic [CW-1:0] idle_run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) idle_run_q <= '0;
      else if (tx_idle_o[g] && pwr_save_en_i && ch_active_i[g])
        idle_run_q <= (idle_run_q == LIMIT) ? idle_run_q : idle_run_q + 1'b1;
      else idle_run_q <= '0;
    end

    // R1
    idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2) |-> (tx_idle_o[g] == $past(squelch_i[g], 2)));

    // R4
    lp_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_lp_o[g] |-> (idle_run_q == LIMIT));

    // R5
    lp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2 && !$past(squelch_i[g], 2)) |-> !ch_lp_o[g]);

    // R8
    inactive_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd1 && !$past(ch_active_i[g])) |-> !ch_lp_o[g]);
  end

  // R7
  all_lp_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_lp_o |-> ((&tx_idle_o) && pwr_save_en_i && (&ch_active_i)));
endmodule

bind lane_idle_pwr_ctrl lane_idle_pwr_chk #(
  .NUM_CH(NUM_CH), .QUAL_CYCLES(QUAL_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .squelch_i(squelch_i),
  .pwr_save_en_i(pwr_save_en_i), .ch_active_i(ch_active_i),
  .tx_idle_o(tx_idle_o), .ch_lp_o(ch_lp_o), .all_lp_o(all_lp_o)
);

// File: tb/lane_idle_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module lane_idle_pwr_ctrl_bench;
  localparam int NCH = 2;
  localparam int Q   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] sq = '0;
  logic [NCH-1:0] act = '0;
  logic ps = 1'b0;
  logic [NCH-1:0] tx_idle, lp;
  logic all_lp;

  always #2 clk = ~clk;  // 250 MHz

  lane_idle_pwr_ctrl #(.NUM_CH(NCH), .QUAL_CYCLES(Q)) u_lane_idle_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .squelch_i(sq), .pwr_save_en_i(ps),
    .ch_active_i(act), .tx_idle_o(tx_idle), .ch_lp_o(lp), .all_lp_o(all_lp)
  );

  int total = 0;
  int bad = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model built from the requirements
  logic [NCH-1:0] m1, m2;
  int run_m [NCH];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0;
      for (int i = 0; i < NCH; i++) run_m[i] <= 0;
    end else begin
      m1 <= sq; m2 <= m1;
      for (int i = 0; i < NCH; i++)
        run_m[i] <= (m2[i] && ps && act[i]) ? ((run_m[i] >= Q) ? Q : run_m[i] + 1) : 0;
    end
  end

  function automatic bit exp_lp(input int i);
    return m2[i] && ps && act[i] && (run_m[i] >= Q);
  endfunction

  always @(negedge clk) begin
    if (model_on) begin
      logic [NCH-1:0] e;
      for (int i = 0; i < NCH; i++) e[i] = exp_lp(i);
      chk(tx_idle == m2, "R1 random idle", int'(tx_idle), int'(m2));
      chk(lp == e, "R4 random lp", int'(lp), int'(e));
      chk(all_lp == (&e), "R7 random all", int'(all_lp), int'(&e));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  // lane ch low power must appear after edge n (counting from the edge after drive)
  task automatic expect_rise(input int ch, input int n, input string tag);
    for (int k = 0; k <= n; k++) begin
      tick();
      if (k == n - 1) chk(lp[ch] == 1'b0, tag, int'(lp[ch]), 0);
      if (k == n)     chk(lp[ch] == 1'b1, tag, int'(lp[ch]), 1);
    end
  endtask

  task automatic burst(input int len, input string tag);
    int lp_cnt = 0;
    int idle_cnt = 0;
    int exp_cnt = (len > Q) ? len - Q : 0;
    sq[0] = 1'b1;
    for (int k = 0; k < len + 4; k++) begin
      tick();
      if (lp[0]) lp_cnt++;
      if (tx_idle[0]) idle_cnt++;
      if (k == len - 1) sq[0] = 1'b0;
    end
    chk(lp_cnt == exp_cnt, tag, lp_cnt, exp_cnt);
    chk(idle_cnt == len, "R1 burst idle length", idle_cnt, len);
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int rl [NCH];
    void'($urandom(32'h1d1e_5eed));
    act = '1; ps = 1'b1; sq = '0;
    repeat (3) tick();
    chk(tx_idle == '0 && lp == '0 && all_lp == 1'b0, "R1 reset state",
        int'({all_lp, lp, tx_idle}), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(tx_idle == '0 && lp == '0, "R1 idle outputs after reset", int'({lp, tx_idle}), 0);

    // R1 latency and R4 entry edge
    sq[0] = 1'b1;
    tick(); chk(tx_idle[0] == 1'b0, "R1 sync stage one", int'(tx_idle[0]), 0);
    tick(); chk(tx_idle[0] == 1'b1, "R1 sync stage two", int'(tx_idle[0]), 1);
    for (int k = 2; k <= Q + 1; k++) begin
      tick();
      if (k == Q)     chk(lp[0] == 1'b0, "R4 before expiry", int'(lp[0]), 0);
      if (k == Q + 1) chk(lp[0] == 1'b1, "R4 at expiry", int'(lp[0]), 1);
    end
    // R2: lane 1 untouched
    chk(tx_idle[1] == 1'b0 && lp[1] == 1'b0, "R2 other lane quiet", int'({lp[1], tx_idle[1]}), 0);
    chk(all_lp == 1'b0, "R7 one lane only", int'(all_lp), 0);

    // R7: second lane joins
    sq[1] = 1'b1;
    for (int k = 0; k <= Q + 1; k++) begin
      tick();
      if (k == Q)     chk(all_lp == 1'b0, "R7 before both", int'(all_lp), 0);
      if (k == Q + 1) chk(all_lp == 1'b1, "R7 both in low power", int'(all_lp), 1);
    end

    // R3: lane 1 inactive, idle still forwarded
    act[1] = 1'b0;
    repeat (Q + 4) tick();
    chk(lp[1] == 1'b0 && tx_idle[1] == 1'b1, "R3 inactive lane", int'({lp[1], tx_idle[1]}), 1);
    chk(lp[0] == 1'b1, "R2 lane 0 unaffected", int'(lp[0]), 1);
    sq[1] = 1'b0; act[1] = 1'b1;
    repeat (3) tick();

    // R5: exit
    sq[0] = 1'b0;
    tick(); chk(lp[0] == 1'b1, "R5 one edge after activity", int'(lp[0]), 1);
    tick(); chk(lp[0] == 1'b0 && tx_idle[0] == 1'b0, "R5 exit latency", int'({lp[0], tx_idle[0]}), 0);
    repeat (3) tick();

    // R8: leave active mode, then return while still idle
    sq[0] = 1'b1;
    repeat (Q + 4) tick();
    chk(lp[0] == 1'b1, "R8 precondition", int'(lp[0]), 1);
    act[0] = 1'b0;
    tick(); chk(lp[0] == 1'b0, "R8 forced out", int'(lp[0]), 0);
    act[0] = 1'b1;
    expect_rise(0, Q - 1, "R8 requalify from zero");

    // R6: strap low
    ps = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < Q + 10; k++) begin tick(); if (lp[0]) seen++; end
      chk(seen == 0, "R6 strap low no low power", seen, 0);
      chk(tx_idle[0] == 1'b1, "R6 idle still forwarded", int'(tx_idle[0]), 1);
    end
    ps = 1'b1;
    expect_rise(0, Q - 1, "R6 strap raised");
    sq[0] = 1'b0;
    repeat (4) tick();

    // R9: boundary bursts
    burst(Q, "R9 burst equal to qualification");
    burst(Q + 1, "R9 burst one over");
    burst(Q - 1, "R9 burst one under");
    burst(Q + 5, "R4 burst five over");

    // random phase
    for (int i = 0; i < NCH; i++) rl[i] = 1;
    model_on = 1'b1;
    for (int c = 0; c < 8000; c++) begin
      @(posedge clk); #1;
      for (int i = 0; i < NCH; i++) begin
        rl[i]--;
        if (rl[i] <= 0) begin
          sq[i] = ~sq[i];
          rl[i] = (sq[i]) ? $urandom_range(Q + 6, Q - 4) : $urandom_range(12, 1);
        end
        if ($urandom_range(199, 0) == 0) act[i] = ~act[i];
      end
      if ($urandom_range(299, 0) == 0) ps = ~ps;
    end
    @(posedge clk); #1;
    model_on = 1'b0;
    finish_run();
  end
endmodule